// File: doc/BRIEF.md
# Serial Eight-Channel Output Latch with Status Readback

This block is a serial-peripheral slave that drives eight on/off channel controls and reports the status of the same eight channels. A host pulls chip select low, exchanges one eight-bit frame, and releases chip select. The host's command bits replace the channel settings. The eight status inputs, captured when the frame begins, are returned on the serial output.

Chip select, serial clock and serial data in are brought into the system clock domain through two-flop synchronizers, and all edges are detected there. The system clock must run at least four times faster than the serial clock. The output latch only changes when chip select is released, so the channels never glitch while bits are shifting. A command bit of 1 switches its channel off and a 0 switches it on. Two flags report frames that are malformed. One flags a frame that started while the serial clock was high. The other flags a frame that did not carry exactly eight clocks.

Top module: `spi_octal_latch`

## Requirements
- R1: After reset, every `chan_off` bit is 1 (all channels off), `sdo_oe` and `sdo` are 0, and both error flags are 0.
- R2: While `cs_n` is high, `sdo_oe` and `sdo` stay 0, and toggling `sclk` and `sdi` leaves `chan_off` and both flags unchanged.
- R3: After `cs_n` falls, `stat_in` is captured and `sdo_oe` goes to 1. Before any `sclk` edge, `sdo` shows `stat_in[7]`.
- R4: In the k-th `sclk` high phase of a frame (k = 1..8), `sdo` shows captured status bit 8-k. The first rising edge holds the bit and each later rising edge advances to the next lower bit.
- R5: `sdi` is sampled on each `sclk` falling edge, most significant bit first. The first bit is for channel 7 and the eighth bit is for channel 0.
- R6: `chan_off` changes only after a `cs_n` rising edge, and then takes the received byte (1 = off, 0 = on). It holds its value throughout shifting.
- R7: A final `sclk` falling edge that arrives at the same time as the `cs_n` rising edge is included in the committed byte and in the bit count.
- R8: If a frame does not carry exactly eight `sclk` falling edges, `count_err` becomes 1 and the latch takes the last eight bits received. Positions not filled are 0, because the receive register clears when `cs_n` falls. A frame with exactly eight edges sets `count_err` back to 0.
- R9: If `cs_n` falls while `sclk` is high, `proto_err` becomes 1 and the following `cs_n` rising edge leaves `chan_off` unchanged. The next clean `cs_n` falling edge clears `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial command data in |
| stat_in | input | 8 | Per-channel status, captured when a frame starts |
| sdo | output | 1 | Serial status data out (0 when not driven) |
| sdo_oe | output | 1 | Output enable for the external tri-state buffer on `sdo` |
| chan_off | output | 8 | Latched channel controls, 1 = channel off |
| proto_err | output | 1 | Frame started while `sclk` was high |
| count_err | output | 1 | Last frame did not carry exactly eight clocks |

## Verification
Two events can land in the same system clock cycle: the last serial clock falling edge and the chip-select rising edge. This happens when the host drops `sclk` and raises `cs_n` at the same instant, so both pass through equal synchronizer depths together. The bench does this on every other frame of a full 256-value command sweep. It judges the result by checking that the committed byte equals the command and that `count_err` stays 0. Losing the last bit would shift the byte and raise the count flag.

// File: rtl/spi_ol_pkg.sv
package spi_ol_pkg;
   // Edge events seen in the system clock domain.
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;
endpackage

// File: rtl/spi_ol_sync.sv
module spi_ol_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                d,
   output logic                q,
   output spi_ol_pkg::edge_t   ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_ol_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= {STAGES{INIT}};
         prev <= INIT;
      end else begin
         pipe <= {pipe[STAGES-2:0], d};
         prev <= pipe[STAGES-1];
      end
   end

   assign q       = pipe[STAGES-1];
   assign ev.rise = q & ~prev;
   assign ev.fall = ~q & prev;
endmodule

// File: rtl/spi_ol_shifter.sv
module spi_ol_shifter #(
   parameter int WIDTH = 8,
   parameter int CNT_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_fall,
   input  logic                cs_rise,
   input  logic                sclk_q,
   input  spi_ol_pkg::edge_t   sclk_ev,
   input  logic                sdi_q,
   input  logic [WIDTH-1:0]    stat_in,
   output logic                active,
   output logic                sdo,
   output logic [WIDTH-1:0]    frame_bits,
   output logic [CNT_W-1:0]    frame_cnt,
   output logic                proto_err
);
   logic [WIDTH-1:0] tx_q, rx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hold_first;
   logic             take_bit;

   assign take_bit = active & sclk_ev.fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         tx_q       <= '0;
         rx_q       <= '0;
         cnt_q      <= '0;
         hold_first <= 1'b1;
         proto_err  <= 1'b0;
      end else if (cs_fall) begin
         active     <= 1'b1;
         tx_q       <= stat_in;
         rx_q       <= '0;
         cnt_q      <= '0;
         hold_first <= 1'b1;
         proto_err  <= sclk_q;
      end else if (active) begin
         if (take_bit) begin
            rx_q  <= frame_bits;
            cnt_q <= frame_cnt;
         end
         if (sclk_ev.rise) begin
            if (hold_first) hold_first <= 1'b0;
            else            tx_q <= {tx_q[WIDTH-2:0], 1'b0};
         end
         if (cs_rise) active <= 1'b0;
      end
   end

   // Frame view including a bit arriving in the same cycle as the commit.
   always_comb begin
      frame_bits = rx_q;
      frame_cnt  = cnt_q;
      if (take_bit) begin
         frame_bits = {rx_q[WIDTH-2:0], sdi_q};
         frame_cnt  = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
      end
   end

   assign sdo = active & tx_q[WIDTH-1];

   // R2: outside a frame the receive register does not move
   a_r2_idle_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !cs_fall) |=> $stable(rx_q));
   // R3: a frame start captures the status inputs
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (tx_q == $past(stat_in)));
   // R4: status only advances on a serial clock rise
   a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_ev.rise && !cs_fall) |=> $stable(tx_q));
endmodule

// File: rtl/spi_ol_latch.sv
module spi_ol_latch #(
   parameter int WIDTH = 8,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic             commit,
   input  logic [WIDTH-1:0] frame_bits,
   input  logic [CNT_W-1:0] frame_cnt,
   output logic [WIDTH-1:0] chan_off,
   output logic             count_err
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_off  <= '1;
         count_err <= 1'b0;
      end else begin
         if (commit)    chan_off  <= frame_bits;
         if (frame_end) count_err <= (frame_cnt != FULL);
      end
   end

   // R6: channel controls hold except on a commit
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(chan_off));
   // R8: the count flag only moves at the end of a frame
   a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(count_err));
endmodule

// File: rtl/spi_octal_latch.sv
module spi_octal_latch #(
   parameter int CHANNELS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                sdi,
   input  logic [CHANNELS-1:0] stat_in,
   output logic                sdo,
   output logic                sdo_oe,
   output logic [CHANNELS-1:0] chan_off,
   output logic                proto_err,
   output logic                count_err
);
   localparam int CNT_W = $clog2(CHANNELS) + 2;

   if (CHANNELS < 2) begin : g_bad_width
      $error("spi_octal_latch: CHANNELS must be at least 2");
   end

   logic              cs_q, sclk_q, sdi_q, active;
   spi_ol_pkg::edge_t cs_ev, sclk_ev, sdi_ev;
   logic [CHANNELS-1:0] frame_bits;
   logic [CNT_W-1:0]    frame_cnt;
   logic                frame_end, commit;

   spi_ol_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_q), .ev(cs_ev));
   spi_ol_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_q), .ev(sclk_ev));
   spi_ol_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sdi (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_q), .ev(sdi_ev));

   spi_ol_shifter #(.WIDTH(CHANNELS), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cs_fall(cs_ev.fall), .cs_rise(cs_ev.rise),
      .sclk_q(sclk_q), .sclk_ev(sclk_ev), .sdi_q(sdi_q),
      .stat_in(stat_in), .active(active), .sdo(sdo),
      .frame_bits(frame_bits), .frame_cnt(frame_cnt),
      .proto_err(proto_err));

   assign frame_end = cs_ev.rise & active;
   assign commit    = frame_end & ~proto_err;

   spi_ol_latch #(.WIDTH(CHANNELS), .CNT_W(CNT_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .commit(commit),
      .frame_bits(frame_bits), .frame_cnt(frame_cnt),
      .chan_off(chan_off), .count_err(count_err));

   assign sdo_oe = active;

   // R3: the driver turns on after a frame start
   a_r3_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
      cs_ev.fall |=> sdo_oe);
   // R9: a frame flagged for a bad start leaves the channels alone
   a_r9_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_err && cs_ev.rise) |=> $stable(chan_off));
   // R2: no drive on the serial output between frames
   a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);
endmodule

// File: tb/spi_octal_latch_bench.sv
module spi_octal_latch_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int H = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic [N-1:0] stat_in = '0;
   logic sdo, sdo_oe, proto_err, count_err;
   logic [N-1:0] chan_off;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [N-1:0] latched;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_octal_latch u_spi_octal_latch (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .stat_in(stat_in), .sdo(sdo), .sdo_oe(sdo_oe), .chan_off(chan_off),
      .proto_err(proto_err), .count_err(count_err));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One host frame: nbits clocks of cmd (MSB of the nbits first).
   task automatic frame(input logic [N-1:0] stat, input logic [15:0] cmd,
                        input int nbits, input bit together, input bit bad_start);
      stat_in = stat;
      if (bad_start) begin
         sclk = 1'b1;
         tick(H);
      end
      cs_n = 1'b0;
      tick(H);
      if (bad_start) begin
         sclk = 1'b0;
         tick(H);
      end else begin
         check("R3 oe", sdo_oe, 1);
         check("R3 first bit", sdo, stat[N-1]);
      end
      for (int b = 0; b < nbits; b++) begin
         tick(H/2);
         sdi = cmd[nbits-1-b];
         tick(H/2);
         sclk = 1'b1;
         tick(H);
         if (!bad_start && b < N) check("R4 status bit", sdo, stat[N-1-b]);
         if (b == 3) check("R6 hold while shifting", chan_off, latched);
         sclk = 1'b0;
         if (b == nbits-1 && together) cs_n = 1'b1;
      end
      if (!together || nbits == 0) begin
         tick(H);
         cs_n = 1'b1;
      end
      tick(8);
   endtask

   function automatic logic [N-1:0] expect_bits(input logic [15:0] cmd, input int nbits);
      logic [15:0] m;
      m = (nbits >= 16) ? 16'hFFFF : 16'((32'd1 << nbits) - 1);
      return N'(cmd & m);
   endfunction

   initial begin
      tick(3);
      check("R1 chan_off", chan_off, 8'hFF);
      check("R1 oe", sdo_oe, 0);
      check("R1 sdo", sdo, 0);
      check("R1 proto_err", proto_err, 0);
      check("R1 count_err", count_err, 0);
      rst_n = 1'b1;
      latched = 8'hFF;
      tick(4);

      // R2: activity while deselected
      for (int i = 0; i < 6; i++) begin
         sdi = i[0];
         sclk = ~sclk;
         tick(H);
         check("R2 oe", sdo_oe, 0);
         check("R2 sdo", sdo, 0);
      end
      sclk = 1'b0;
      tick(H);
      check("R2 chan_off", chan_off, latched);
      check("R2 count_err", count_err, 0);

      // R5/R6/R7: full sweep of commands, alternate coincident release
      for (int i = 0; i < 256; i++) begin
         logic [N-1:0] st;
         st = N'(i * 37 + 11) ^ 8'hA5;
         frame(st, 16'(i), N, i[0], 1'b0);
         latched = N'(i);
         check(i[0] ? "R7 coincident commit" : "R5 R6 commit", chan_off, latched);
         check("R8 count ok", count_err, 0);
         check("R9 clean", proto_err, 0);
      end

      // R8: short frame
      frame(8'h3C, 16'h0015, 5, 1'b0, 1'b0);
      latched = expect_bits(16'h0015, 5);
      check("R8 short latch", chan_off, latched);
      check("R8 short flag", count_err, 1);
      // R8: long frame keeps last eight bits
      frame(8'hC3, 16'h05A3, 11, 1'b0, 1'b0);
      latched = expect_bits(16'h05A3, 11);
      check("R8 long latch", chan_off, latched);
      check("R8 long flag", count_err, 1);
      frame(8'h81, 16'h0066, N, 1'b0, 1'b0);
      latched = 8'h66;
      check("R8 clear", count_err, 0);
      check("R8 next latch", chan_off, latched);

      // R9: bad start skips the commit
      frame(8'h18, 16'h000F, N, 1'b0, 1'b1);
      check("R9 flag", proto_err, 1);
      check("R9 no commit", chan_off, latched);
      frame(8'h18, 16'h0099, N, 1'b0, 1'b0);
      latched = 8'h99;
      check("R9 cleared", proto_err, 0);
      check("R9 resumes", chan_off, latched);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule